// File: doc/BRIEF.md
# Button-Stepped Servo Pulse Controller

This block drives a hobby servo from a 50 MHz clock. It repeats a 20 ms frame. Each frame opens with a high pulse, and the width of that pulse sets the servo angle. The block holds a commanded angle between 0 and 180 degrees, and two push buttons move that angle. A press of the "up" button adds a fixed step of 5 degrees. A press of the "down" button subtracts the same step.

Pulse width is a linear function of the angle. An angle of 0 gives 0.6 ms, 90 gives 1.5 ms and 180 gives 2.4 ms. This is 10 µs per degree, or 500 clock cycles per degree at 50 MHz.

Each button input passes through three stages before it reaches the angle register:
- a two-flop synchroniser;
- a debounce filter that needs about 10 ms of stable input;
- a rising-edge detector, so one press makes exactly one step.

The angle stops at both ends of its range and does not wrap. The pulse generator reads a new angle only when a new frame starts. The current angle is also available as an output.

Top module: `servo_stepper`

## Requirements
- R1: While synchronous reset `rst` is high, and on the first cycle after it is released, `angle` reads 90 and `pwm_out` is high. The first frame begins at the cycle reset is released.
- R2: Rising edges of `pwm_out` are exactly FRAME_CYC cycles apart (default 1,000,000).
- R3: Each frame, `pwm_out` stays high for MIN_WIDTH + CYC_PER_DEG × angle cycles (defaults 30,000 and 500), then stays low for the rest of the frame.
- R4: A debounced press of `btn_up` raises `angle` by STEP_DEG (5). A debounced press of `btn_down` lowers it by the same amount.
- R5: Holding a button down produces exactly one step, however long it is held.
- R6: `angle` never goes above MAX_DEG (180) or below 0. An up press at 180 or a down press at 0 leaves it unchanged.
- R7: When up and down presses are registered in the same cycle, `angle` does not change.
- R8: A button level shorter than DEB_CYC cycles (default 500,000) is ignored and makes no step.
- R9: A new angle takes effect only from the next frame start. A pulse already under way keeps the width it started with.
- R10: `angle` is an 8-bit unsigned value in degrees and follows the register within one cycle of a press.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| btn_up | input | 1 | Raw (asynchronous, bouncy) increment button |
| btn_down | input | 1 | Raw decrement button |
| pwm_out | output | 1 | Servo control pulse |
| angle | output | 8 | Current commanded angle in degrees |

## Verification
Some properties are checked by assertions on every cycle:
- the angle stays in range and holds at the saturated ends;
- the angle holds when up and down presses coincide;
- a press pulse lasts exactly one cycle;
- the debounce counter stays bounded;
- the latched pulse width changes only at a frame boundary and always lies within the legal range.

Other behaviour can only be shown by the bench scenarios, which run with shortened frame and debounce parameters:
- the exact frame period and per-angle pulse width, measured at the output;
- rejection of short glitches;
- one step per long hold;
- the rule that a press landing mid-pulse leaves that pulse intact and alters only the next one.

// File: rtl/servo_pkg.sv
package servo_pkg;
  localparam int ANGLE_W = 8;

  typedef enum logic [1:0] {
    CMD_HOLD = 2'd0,
    CMD_UP   = 2'd1,
    CMD_DOWN = 2'd2
  } step_cmd_e;

  function automatic step_cmd_e decode_cmd(input logic up, input logic down);
    if (up && !down)      return CMD_UP;
    else if (down && !up) return CMD_DOWN;
    else                  return CMD_HOLD;
  endfunction
endpackage

// File: rtl/servo_btn_cond.sv
module servo_btn_cond #(
  parameter int DEB_CYC = 500000
) (
  input  logic clk,
  input  logic rst,
  input  logic btn_raw,
  output logic press
);
  localparam int DW = $clog2(DEB_CYC + 1);

  logic          sync1, sync2, level;
  logic [DW-1:0] stable_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync1      <= 1'b0;
      sync2      <= 1'b0;
      level      <= 1'b0;
      stable_cnt <= '0;
      press      <= 1'b0;
    end else begin
      sync1 <= btn_raw;
      sync2 <= sync1;
      press <= 1'b0;
      if (sync2 == level) begin
        stable_cnt <= '0;
      end else if (stable_cnt == DW'(DEB_CYC - 1)) begin
        level      <= sync2;
        stable_cnt <= '0;
        press      <= sync2;
      end else begin
        stable_cnt <= stable_cnt + 1'b1;
      end
    end
  end

  // R5: one press produces a single-cycle pulse
  assert_single_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    press |=> !press);
  // R5: a press is only reported together with a high filtered level
  assert_press_high_R5: assert property (@(posedge clk) disable iff (rst)
    press |-> level);
  // R8: filter counter never passes its window
  assert_deb_bound_R8: assert property (@(posedge clk) disable iff (rst)
    stable_cnt < DW'(DEB_CYC));
endmodule

// File: rtl/servo_angle_reg.sv
module servo_angle_reg
  import servo_pkg::*;
#(
  parameter int MAX_DEG   = 180,
  parameter int STEP_DEG  = 5,
  parameter int RESET_DEG = 90
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               up_press,
  input  logic               down_press,
  output logic [ANGLE_W-1:0] angle
);
  localparam logic [ANGLE_W-1:0] MAX_A  = ANGLE_W'(MAX_DEG);
  localparam logic [ANGLE_W-1:0] STEP_A = ANGLE_W'(STEP_DEG);

  step_cmd_e cmd;
  assign cmd = decode_cmd(up_press, down_press);

  always_ff @(posedge clk) begin
    if (rst) begin
      angle <= ANGLE_W'(RESET_DEG);
    end else begin
      case (cmd)
        CMD_UP:   angle <= (angle >= MAX_A - STEP_A) ? MAX_A : angle + STEP_A;
        CMD_DOWN: angle <= (angle <= STEP_A) ? '0 : angle - STEP_A;
        default:  angle <= angle;
      endcase
    end
  end

  // R6: angle stays in range
  assert_angle_range_R6: assert property (@(posedge clk) disable iff (rst)
    angle <= MAX_A);
  // R6: up at the top end holds
  assert_top_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (angle == MAX_A && up_press && !down_press) |=> angle == MAX_A);
  // R6: down at zero holds
  assert_bottom_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (angle == '0 && down_press && !up_press) |=> angle == '0);
  // R7: coincident presses leave angle alone
  assert_both_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (up_press && down_press) |=> $stable(angle));
endmodule

// File: rtl/servo_pwm_frame.sv
module servo_pwm_frame
  import servo_pkg::*;
#(
  parameter int FRAME_CYC   = 1000000,
  parameter int MIN_WIDTH   = 30000,
  parameter int CYC_PER_DEG = 500,
  parameter int MAX_DEG     = 180,
  parameter int RESET_DEG   = 90
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ANGLE_W-1:0] angle,
  output logic               pwm_out
);
  localparam int CW = $clog2(FRAME_CYC + 1);
  localparam logic [CW-1:0] LAST      = CW'(FRAME_CYC - 1);
  localparam logic [CW-1:0] W_RESET   = CW'(MIN_WIDTH + CYC_PER_DEG * RESET_DEG);
  localparam logic [CW-1:0] W_MIN     = CW'(MIN_WIDTH);
  localparam logic [CW-1:0] W_MAX     = CW'(MIN_WIDTH + CYC_PER_DEG * MAX_DEG);

  logic [CW-1:0] frame_cnt, width_q, width_next;

  assign width_next = W_MIN + CW'(CYC_PER_DEG) * CW'(angle);

  always_ff @(posedge clk) begin
    if (rst) begin
      frame_cnt <= '0;
      width_q   <= W_RESET;
    end else if (frame_cnt == LAST) begin
      frame_cnt <= '0;
      width_q   <= width_next;
    end else begin
      frame_cnt <= frame_cnt + 1'b1;
    end
  end

  assign pwm_out = (frame_cnt < width_q);

  // R9: width only changes at the frame boundary
  assert_width_frozen_R9: assert property (@(posedge clk) disable iff (rst)
    (frame_cnt != '0) |-> $stable(width_q));
  // R3: latched width lies within the mapped range
  assert_width_range_R3: assert property (@(posedge clk) disable iff (rst)
    (width_q >= W_MIN) && (width_q <= W_MAX));
  // R2: counter wraps to zero after the last frame cycle
  assert_frame_wrap_R2: assert property (@(posedge clk) disable iff (rst)
    (frame_cnt == LAST) |=> (frame_cnt == '0));
endmodule

// File: rtl/servo_stepper.sv
module servo_stepper
  import servo_pkg::*;
#(
  parameter int FRAME_CYC   = 1000000,
  parameter int MIN_WIDTH   = 30000,
  parameter int CYC_PER_DEG = 500,
  parameter int MAX_DEG     = 180,
  parameter int STEP_DEG    = 5,
  parameter int RESET_DEG   = 90,
  parameter int DEB_CYC     = 500000
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         btn_up,
  input  logic         btn_down,
  output logic         pwm_out,
  output logic [7:0]   angle
);
  localparam int NBTN = 2;

  logic [NBTN-1:0] raw, press;
  assign raw = {btn_down, btn_up};

  for (genvar g = 0; g < NBTN; g++) begin : g_btn
    servo_btn_cond #(.DEB_CYC(DEB_CYC)) u_cond (
      .clk(clk), .rst(rst), .btn_raw(raw[g]), .press(press[g])
    );
  end

  logic [ANGLE_W-1:0] angle_q;

  servo_angle_reg #(
    .MAX_DEG(MAX_DEG), .STEP_DEG(STEP_DEG), .RESET_DEG(RESET_DEG)
  ) u_angle (
    .clk(clk), .rst(rst), .up_press(press[0]), .down_press(press[1]),
    .angle(angle_q)
  );

  servo_pwm_frame #(
    .FRAME_CYC(FRAME_CYC), .MIN_WIDTH(MIN_WIDTH), .CYC_PER_DEG(CYC_PER_DEG),
    .MAX_DEG(MAX_DEG), .RESET_DEG(RESET_DEG)
  ) u_pwm (
    .clk(clk), .rst(rst), .angle(angle_q), .pwm_out(pwm_out)
  );

  assign angle = angle_q;
endmodule

// File: tb/servo_stepper_test.sv
module servo_stepper_test;
  localparam int FRAME = 2000;
  localparam int MINW  = 60;
  localparam int CPD   = 2;
  localparam int DEB   = 16;
  localparam int HOLD  = DEB + 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic btn_up = 1'b0;
  logic btn_down = 1'b0;
  logic pwm_out;
  logic [7:0] angle;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  servo_stepper #(
    .FRAME_CYC(FRAME), .MIN_WIDTH(MINW), .CYC_PER_DEG(CPD),
    .MAX_DEG(180), .STEP_DEG(5), .RESET_DEG(90), .DEB_CYC(DEB)
  ) uut (
    .clk(clk), .rst(rst), .btn_up(btn_up), .btn_down(btn_down),
    .pwm_out(pwm_out), .angle(angle)
  );

  function automatic int exp_width(input int a);
    return MINW + CPD * a;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // measure the next full pulse: returns high count and period
  task automatic measure(output int hi, output int per);
    int lo;
    hi = 0; lo = 0;
    while (pwm_out !== 1'b0) @(negedge clk);
    while (pwm_out !== 1'b1) @(negedge clk);
    while (pwm_out === 1'b1) begin hi++; @(negedge clk); end
    while (pwm_out === 1'b0) begin lo++; @(negedge clk); end
    per = hi + lo;
  endtask

  task automatic press(input bit up, input bit down);
    btn_up = up; btn_down = down;
    cycles(HOLD);
    btn_up = 1'b0; btn_down = 1'b0;
    cycles(HOLD);
  endtask

  task automatic t_reset;
    int hi, per;
    @(negedge clk);
    check(angle == 8'd90, "R1 angle in reset", angle, 90);
    check(pwm_out == 1'b1, "R1 pwm high in reset", pwm_out, 1);
    rst = 1'b0;
    hi = 0;
    while (pwm_out === 1'b1) begin hi++; @(negedge clk); end
    check(hi == exp_width(90) - 1 || hi == exp_width(90), "R1 first pulse", hi, exp_width(90));
    measure(hi, per);
    check(per == FRAME, "R2 period", per, FRAME);
    check(hi == exp_width(90), "R3 width at 90", hi, exp_width(90));
    check(angle == 8'd90, "R10 angle port", angle, 90);
  endtask

  task automatic t_steps;
    int hi, per;
    press(1'b1, 1'b0);
    check(angle == 8'd95, "R4 up step", angle, 95);
    press(1'b0, 1'b1);
    press(1'b0, 1'b1);
    check(angle == 8'd85, "R4 down steps", angle, 85);
    measure(hi, per);
    measure(hi, per);
    check(hi == exp_width(85), "R3 width at 85", hi, exp_width(85));
    check(per == FRAME, "R2 period at 85", per, FRAME);
  endtask

  task automatic t_long_hold;
    btn_up = 1'b1;
    cycles(10 * DEB);
    btn_up = 1'b0;
    cycles(HOLD);
    check(angle == 8'd90, "R5 long hold one step", angle, 90);
  endtask

  task automatic t_glitch;
    btn_up = 1'b1;
    cycles(DEB / 2);
    btn_up = 1'b0;
    cycles(HOLD);
    btn_down = 1'b1;
    cycles(DEB - 6);
    btn_down = 1'b0;
    cycles(HOLD);
    check(angle == 8'd90, "R8 glitches ignored", angle, 90);
  endtask

  task automatic t_both;
    press(1'b1, 1'b1);
    check(angle == 8'd90, "R7 both pressed", angle, 90);
  endtask

  task automatic t_midpulse;
    int hi, per;
    while (pwm_out !== 1'b0) @(negedge clk);
    while (pwm_out !== 1'b1) @(negedge clk);
    btn_up = 1'b1;
    hi = 0;
    while (pwm_out === 1'b1) begin
      hi++;
      if (hi == HOLD) btn_up = 1'b0;
      @(negedge clk);
    end
    btn_up = 1'b0;
    check(angle == 8'd95, "R9 angle moved mid-pulse", angle, 95);
    check(hi == exp_width(90), "R9 running pulse kept", hi, exp_width(90));
    measure(hi, per);
    check(hi == exp_width(95), "R9 next frame uses new angle", hi, exp_width(95));
  endtask

  task automatic t_saturate;
    int hi, per;
    for (int k = 0; k < 20; k++) press(1'b1, 1'b0);
    check(angle == 8'd180, "R6 top saturation", angle, 180);
    measure(hi, per);
    measure(hi, per);
    check(hi == exp_width(180), "R3 width at 180", hi, exp_width(180));
    for (int k = 0; k < 38; k++) press(1'b0, 1'b1);
    check(angle == 8'd0, "R6 bottom saturation", angle, 0);
    measure(hi, per);
    measure(hi, per);
    check(hi == exp_width(0), "R3 width at 0", hi, exp_width(0));
    check(per == FRAME, "R2 period at 0", per, FRAME);
  endtask

  initial begin
    cycles(3);
    t_reset();
    t_steps();
    t_long_hold();
    t_glitch();
    t_both();
    t_midpulse();
    t_saturate();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    cycles(190000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule